// File: doc/BRIEF.md
# Card slot power and detect sequencer

This block manages one removable card slot. It samples the card-detect pin through a synchroniser and a debounce filter, applies a configurable polarity, and can be told to treat the slot as always occupied. The result is a clean presence flag and a one-cycle event pulse for each accepted insertion or removal.

The block also drives the slot power pin and an optional device-enable control pin in a fixed order. All waits are counted in milliseconds from an external tick.

- On a power-up request it applies power, waits a programmable settle time, and then toggles the control pin. A programmable guard time is held both before and after that toggle. After the second guard time the slot is reported ready.
- Power is removed only on an explicit power-down request, or when the card leaves. A programmable off time must then pass before power can be applied again.
- Polarity bits invert the meaning of the detect pin, the power pin and the control pin, each on its own.

Top module: `slot_pwr_seq`

## Requirements
- R1: After reset the power pin is at its off level, the control pin is at its first level, and present, ready and the event pulse are all 0.
- R2: With the detect polarity bit at 0, a low detect level means a card is present. A changed level is accepted only after DEB_MS consecutive millisecond ticks in which it differs from the accepted level. A shorter glitch is discarded.
- R3: With the detect polarity bit at 1, a high detect level means a card is present.
- R4: With force-present at 1, present reads 1 whatever the detect pin does. Detect-pin changes then raise no event pulse and cause no power-off.
- R5: The power pin's on level is low when the power polarity bit is 0, and high when that bit is 1.
- R6: After power is applied, ready rises only after the power-on delay of ticks has passed. When the control pin is enabled, each of the two control guard delays must also pass.
- R7: The control pin idles high and goes low midway through power-up, between its two guard delays. The control polarity bit reverses both levels. With the control pin disabled, it stays at its first level.
- R8: A power-down request turns power off, clears ready and returns the control pin to its first level. Power-up requests are ignored during the following power-off delay.
- R9: Once ready, power stays on and ready stays set while the card remains present and no power-down request arrives, no matter how many ticks pass.
- R10: Every accepted presence change raises the event pulse for exactly one cycle. A removal while powered starts the power-off sequence.
- R11: A power-up request while no card is present has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| det_pin_i | input | 1 | Raw card-detect pin, asynchronous |
| ms_tick_i | input | 1 | One-cycle pulse each millisecond |
| pwr_up_req_i | input | 1 | Request to power and initialise the slot |
| pwr_dn_req_i | input | 1 | Request to power the slot down |
| cfg_det_inv_i | input | 1 | 1: high detect level means present |
| cfg_force_i | input | 1 | 1: slot always reports a card |
| cfg_pwr_inv_i | input | 1 | 1: power pin on level is high |
| cfg_ctl_inv_i | input | 1 | 1: control pin goes low first, then high |
| cfg_ctl_en_i | input | 1 | 1: run the control pin toggle and its guard delays |
| cfg_on_dly_i | input | DLY_W | Power-on settle delay in ms |
| cfg_off_dly_i | input | DLY_W | Power-off hold delay in ms |
| cfg_ctl_dly_i | input | DLY_W | Guard delay in ms before and after the control toggle |
| pwr_pin_o | output | 1 | Slot power pin |
| ctl_pin_o | output | 1 | Device-enable control pin |
| present_o | output | 1 | Accepted card presence |
| ready_o | output | 1 | Power-up sequence complete |
| evt_irq_o | output | 1 | One-cycle insert/remove event |

## Verification
The bench builds the block with DLY_W=10, DEB_MS=4 and SYNC_STAGES=2. It programs delays of 6, 4 and 3 ms and drives the tick directly, so every delay boundary is reached within a few hundred cycles. With these values the bench can probe the tick just before and just after each boundary: the debounce acceptance, the control toggle and the ready rise. It can also cover every polarity combination and the force-present bypass in one short run.

// File: rtl/slot_pwr_pkg.sv
package slot_pwr_pkg;
   typedef enum logic [2:0] {
      SQ_OFF      = 3'd0,
      SQ_ON_WAIT  = 3'd1,
      SQ_CTL_PRE  = 3'd2,
      SQ_CTL_POST = 3'd3,
      SQ_READY    = 3'd4,
      SQ_OFF_WAIT = 3'd5
   } seq_state_e;
endpackage

// File: rtl/slot_det_filter.sv
module slot_det_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_MS      = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic inv_i,
   input  logic tick_i,
   output logic stable_o,
   output logic chg_o
);
   localparam int CW = (DEB_MS > 2) ? $clog2(DEB_MS) : 1;
   localparam logic [CW-1:0] CNT_LAST = CW'(DEB_MS - 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   raw_present;
   logic [CW-1:0]          cnt_q;
   logic                   stable_q, chg_q;

   // synchroniser chain, idles at the pin's pulled-up level
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[0] <= 1'b1;
      else        sync_q[0] <= pin_i;
   end
   for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[i] <= 1'b1;
         else        sync_q[i] <= sync_q[i-1];
      end
   end

   assign raw_present = inv_i ? sync_q[SYNC_STAGES-1] : ~sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         stable_q <= 1'b0;
         chg_q    <= 1'b0;
      end else begin
         chg_q <= 1'b0;
         if (raw_present == stable_q) begin
            cnt_q <= '0;
         end else if (tick_i) begin
            if (cnt_q == CNT_LAST) begin
               cnt_q    <= '0;
               stable_q <= raw_present;
               chg_q    <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign stable_o = stable_q;
   assign chg_o    = chg_q;
endmodule

// File: rtl/slot_ms_timer.sv
module slot_ms_timer #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   input  logic         tick_i,
   output logic         done_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_q <= '0;
      else if (load_i)                  cnt_q <= val_i;
      else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = (cnt_q == '0);
endmodule

// File: rtl/slot_pwr_seq.sv
module slot_pwr_seq
   import slot_pwr_pkg::*;
#(
   parameter int DLY_W       = 12,
   parameter int DEB_MS      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             det_pin_i,
   input  logic             ms_tick_i,
   input  logic             pwr_up_req_i,
   input  logic             pwr_dn_req_i,
   input  logic             cfg_det_inv_i,
   input  logic             cfg_force_i,
   input  logic             cfg_pwr_inv_i,
   input  logic             cfg_ctl_inv_i,
   input  logic             cfg_ctl_en_i,
   input  logic [DLY_W-1:0] cfg_on_dly_i,
   input  logic [DLY_W-1:0] cfg_off_dly_i,
   input  logic [DLY_W-1:0] cfg_ctl_dly_i,
   output logic             pwr_pin_o,
   output logic             ctl_pin_o,
   output logic             present_o,
   output logic             ready_o,
   output logic             evt_irq_o
);
   if (DEB_MS < 2) begin : g_bad_deb
      $error("DEB_MS must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DLY_W < 1) begin : g_bad_dly
      $error("DLY_W must be at least 1");
   end

   seq_state_e       state_q, state_d;
   logic             det_stable, det_chg, slot_present, drop_req;
   logic             tmr_done, tmr_load, ctl_flip_q, pwr_on;
   logic [DLY_W-1:0] tmr_val;

   slot_det_filter #(.SYNC_STAGES(SYNC_STAGES), .DEB_MS(DEB_MS)) u_filt (
      .clk(clk), .rst_n(rst_n), .pin_i(det_pin_i), .inv_i(cfg_det_inv_i),
      .tick_i(ms_tick_i), .stable_o(det_stable), .chg_o(det_chg));

   slot_ms_timer #(.W(DLY_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val),
      .tick_i(ms_tick_i), .done_o(tmr_done));

   assign slot_present = cfg_force_i | det_stable;
   assign drop_req     = pwr_dn_req_i | ~slot_present;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SQ_OFF:      if (pwr_up_req_i && slot_present) state_d = SQ_ON_WAIT;
         SQ_ON_WAIT:  if (drop_req) state_d = SQ_OFF_WAIT;
                      else if (tmr_done) state_d = cfg_ctl_en_i ? SQ_CTL_PRE : SQ_READY;
         SQ_CTL_PRE:  if (drop_req) state_d = SQ_OFF_WAIT;
                      else if (tmr_done) state_d = SQ_CTL_POST;
         SQ_CTL_POST: if (drop_req) state_d = SQ_OFF_WAIT;
                      else if (tmr_done) state_d = SQ_READY;
         SQ_READY:    if (drop_req) state_d = SQ_OFF_WAIT;
         SQ_OFF_WAIT: if (tmr_done) state_d = SQ_OFF;
         default:     state_d = SQ_OFF;
      endcase
   end

   always_comb begin
      unique case (state_d)
         SQ_ON_WAIT:              tmr_val = cfg_on_dly_i;
         SQ_CTL_PRE, SQ_CTL_POST: tmr_val = cfg_ctl_dly_i;
         SQ_OFF_WAIT:             tmr_val = cfg_off_dly_i;
         default:                 tmr_val = '0;
      endcase
   end
   assign tmr_load = (state_d != state_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= SQ_OFF;
         ctl_flip_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_d == SQ_CTL_POST)      ctl_flip_q <= 1'b1;
         else if (state_d == SQ_OFF_WAIT) ctl_flip_q <= 1'b0;
      end
   end

   assign pwr_on    = (state_q == SQ_ON_WAIT) || (state_q == SQ_CTL_PRE) ||
                      (state_q == SQ_CTL_POST) || (state_q == SQ_READY);
   assign pwr_pin_o = pwr_on ? cfg_pwr_inv_i : ~cfg_pwr_inv_i;
   assign ctl_pin_o = ctl_flip_q ? cfg_ctl_inv_i : ~cfg_ctl_inv_i;
   assign present_o = slot_present;
   assign ready_o   = (state_q == SQ_READY);
   assign evt_irq_o = det_chg & ~cfg_force_i;
endmodule

// File: rtl/slot_pwr_seq_chk.sv
module slot_pwr_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic pwr_up_req_i,
   input logic pwr_dn_req_i,
   input logic cfg_pwr_inv_i,
   input logic cfg_ctl_inv_i,
   input logic pwr_pin_o,
   input logic ctl_pin_o,
   input logic present_o,
   input logic ready_o,
   input logic evt_irq_o
);
   AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      evt_irq_o |=> !evt_irq_o); // R10

   AST_ABSENT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !present_o |=> !ready_o); // R10

   AST_READY_IMPLIES_POWER: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> (pwr_pin_o == cfg_pwr_inv_i)); // R5

   AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && present_o && !pwr_dn_req_i) |=> ready_o); // R9

   AST_POWER_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_pin_o == cfg_pwr_inv_i) |-> $past(pwr_up_req_i)); // R11

   AST_CTL_STEADY_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && $past(ready_o) && $stable(cfg_ctl_inv_i)) |-> $stable(ctl_pin_o)); // R7
endmodule

bind slot_pwr_seq slot_pwr_seq_chk u_chk (.*);

// File: tb/slot_pwr_seq_tb.sv
module slot_pwr_seq_tb;
   localparam int DLY_W = 10;
   localparam int DEB   = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic det_pin = 1'b1, tick = 1'b0, up_req = 1'b0, dn_req = 1'b0;
   logic det_inv = 1'b0, force_p = 1'b0, pwr_inv = 1'b0, ctl_inv = 1'b0, ctl_en = 1'b1;
   logic [DLY_W-1:0] on_dly = 10'd6, off_dly = 10'd4, ctl_dly = 10'd3;
   logic pwr_pin, ctl_pin, present, ready, irq;

   int nchk = 0;
   int nbad = 0;
   bit exp_q[$];
   bit done_flag = 1'b0;

   always #5 clk = ~clk;

   slot_pwr_seq #(.DLY_W(DLY_W), .DEB_MS(DEB), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .det_pin_i(det_pin), .ms_tick_i(tick),
      .pwr_up_req_i(up_req), .pwr_dn_req_i(dn_req),
      .cfg_det_inv_i(det_inv), .cfg_force_i(force_p), .cfg_pwr_inv_i(pwr_inv),
      .cfg_ctl_inv_i(ctl_inv), .cfg_ctl_en_i(ctl_en),
      .cfg_on_dly_i(on_dly), .cfg_off_dly_i(off_dly), .cfg_ctl_dly_i(ctl_dly),
      .pwr_pin_o(pwr_pin), .ctl_pin_o(ctl_pin), .present_o(present),
      .ready_o(ready), .evt_irq_o(irq));

   task automatic chk(input string tag, input logic act, input logic exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_up();
      @(negedge clk) up_req = 1'b1;
      @(negedge clk) up_req = 1'b0;
   endtask

   task automatic pulse_dn();
      @(negedge clk) dn_req = 1'b1;
      @(negedge clk) dn_req = 1'b0;
   endtask

   // scoreboard monitor: each event pulse must match the next expected presence value
   always @(negedge clk) begin
      if (rst_n && irq) begin
         nchk++;
         if (exp_q.size() == 0) begin
            nbad++;
            $display("FAIL R10 unexpected event act=%0b exp=none", present);
         end else begin
            bit e;
            e = exp_q.pop_front();
            if (present !== e) begin
               nbad++;
               $display("FAIL R10 event presence act=%0b exp=%0b", present, e);
            end
         end
      end
   end

   initial begin
      for (int c = 0; c < 20000; c++) @(posedge clk);
      if (!done_flag) begin
         nbad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1 reset state
      chk("R1 pwr", pwr_pin, 1'b1);
      chk("R1 ctl", ctl_pin, 1'b1);
      chk("R1 present", present, 1'b0);
      chk("R1 ready", ready, 1'b0);
      chk("R1 irq", irq, 1'b0);

      // R11 power-up without card
      pulse_up();
      idle(1);
      chk("R11 no power", pwr_pin, 1'b1);

      // R2 short glitch discarded
      det_pin = 1'b0; idle(4); ticks(2);
      det_pin = 1'b1; idle(4); ticks(4);
      chk("R2 glitch", present, 1'b0);

      // R2 insertion accepted after DEB ticks
      det_pin = 1'b0; idle(4); ticks(DEB - 1);
      chk("R2 before boundary", present, 1'b0);
      exp_q.push_back(1'b1);
      ticks(1);
      chk("R2 present", present, 1'b1);

      // R5 R6 R7 power-up sequence, default polarities
      pulse_up();
      idle(1);
      chk("R5 pwr low on", pwr_pin, 1'b0);
      chk("R7 ctl first", ctl_pin, 1'b1);
      ticks(5);
      chk("R6 not yet ready", ready, 1'b0);
      ticks(1);
      chk("R7 pre guard ctl", ctl_pin, 1'b1);
      ticks(3);
      chk("R7 ctl flipped", ctl_pin, 1'b0);
      chk("R6 ready in post", ready, 1'b0);
      ticks(2);
      chk("R6 ready early", ready, 1'b0);
      ticks(1);
      chk("R6 ready", ready, 1'b1);

      // R9 stays powered while idle
      ticks(20);
      chk("R9 ready held", ready, 1'b1);
      chk("R9 pwr held", pwr_pin, 1'b0);

      // R8 power-down, request during off delay ignored
      pulse_dn();
      idle(1);
      chk("R8 pwr off", pwr_pin, 1'b1);
      chk("R8 ready clr", ready, 1'b0);
      chk("R8 ctl back", ctl_pin, 1'b1);
      pulse_up();
      idle(1);
      chk("R8 up ignored", pwr_pin, 1'b1);
      ticks(4);
      chk("R8 still off", pwr_pin, 1'b1);
      pulse_up();
      idle(1);
      chk("R8 reapplied", pwr_pin, 1'b0);
      ticks(12);
      chk("R6 ready again", ready, 1'b1);

      // R10 removal while powered forces power-off
      det_pin = 1'b1; idle(4); ticks(DEB - 1);
      chk("R10 present before", present, 1'b1);
      exp_q.push_back(1'b0);
      ticks(1);
      chk("R10 removed", present, 1'b0);
      chk("R10 pwr off", pwr_pin, 1'b1);
      chk("R10 ready clr", ready, 1'b0);
      ticks(4);

      // R5 R7 reversed polarities, R3 reversed detect
      pwr_inv = 1'b1; ctl_inv = 1'b1;
      idle(1);
      chk("R5 inv off level", pwr_pin, 1'b0);
      chk("R7 inv first", ctl_pin, 1'b0);
      det_inv = 1'b1;
      exp_q.push_back(1'b1);
      idle(3); ticks(DEB);
      chk("R3 high present", present, 1'b1);
      pulse_up();
      idle(1);
      chk("R5 inv on level", pwr_pin, 1'b1);
      ticks(6 + 3);
      chk("R7 inv flipped", ctl_pin, 1'b1);
      ticks(3);
      chk("R6 ready inv", ready, 1'b1);
      pulse_dn();
      ticks(4);

      // R7 control disabled: ready right after on delay, pin unchanged
      ctl_en = 1'b0;
      pulse_up();
      ticks(6);
      chk("R7 noctl ready", ready, 1'b1);
      chk("R7 noctl level", ctl_pin, 1'b0);
      pulse_dn();
      ticks(4);

      // R4 force-present
      det_inv = 1'b0;
      exp_q.push_back(1'b0);
      idle(3); ticks(DEB);
      chk("R4 absent first", present, 1'b0);
      force_p = 1'b1;
      idle(1);
      chk("R4 forced", present, 1'b1);
      det_pin = 1'b0; idle(4); ticks(DEB);
      det_pin = 1'b1; idle(4); ticks(DEB);
      chk("R4 still present", present, 1'b1);
      pulse_up();
      idle(1);
      chk("R4 power with force", pwr_pin, 1'b1);
      ticks(7);
      chk("R4 no removal drop", ready, 1'b1);

      idle(2);
      nchk++;
      if (exp_q.size() != 0) begin
         nbad++;
         $display("FAIL R10 missing events act=%0d exp=0", exp_q.size());
      end
      done_flag = 1'b1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end
endmodule